// File: doc/BRIEF.md
# PWM Output Steering Unit

This block produces one pulse-width-modulated waveform from a small internal timebase and routes it to any combination of four output pins, named A, B, C and D. Each pin has its own steering bit. A pin whose steering bit is clear shows a general-purpose data bit instead. Polarity is set for each pin pair (A with C, B with D). A shutdown input parks the steered pins at their inactive level and leaves the other pins alone.

A new steering pattern can be applied in one of two ways. It can take effect on the very next clock, which may cut a pulse short. It can also be held until the timebase next wraps, so that only whole pulses appear on the pins. Period and duty values are double-buffered and take effect at a period boundary.

A status flag goes high once the first full period after enabling has completed. Software can use it to know when turning on the pin drivers is safe. Each pin reports a drive-enable next to its value. When the drive-enable is low, the pin is high-impedance and its value reads 0.

All pins are plain control and status signals, sampled on the rising clock edge. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_steer`

## Requirements
- R1: After reset the status flag is 0, every steering bit is clear (pins show their data bits), and no pending steering update exists.
- R2: The counter runs from 0 up to the active period value P and wraps, so each period lasts P+1 cycles. The raw waveform is 1 while the count is below the active duty value and the block is enabled. An active-high steered pin follows it.
- R3: A pin whose active steering bit is clear outputs its data bit, whatever the waveform does.
- R4: A steering write with the sync input at 0 changes the active steering bits on the clock after the write strobe, even in the middle of a pulse. It also discards any pending update.
- R5: A steering write with the sync input at 1 is held. It becomes active on the clock on which the counter wraps to 0. A later write replaces a held value that has not yet been applied.
- R6: Polarity bit 1 inverts pins A and C (bits 0 and 2), and polarity bit 0 inverts pins B and D (bits 1 and 3). So 00 is all active-high, 01 inverts only B/D, 10 inverts only A/C and 11 inverts all four.
- R7: While shutdown is 1, each steered pin outputs its inactive level, which equals its pair's polarity bit. Unsteered pins keep their data bit.
- R8: A pin drives only when its output-enable bit is 1. Otherwise its drive flag is 0 and its value reads 0.
- R9: The status flag rises on the first counter wrap after enabling, which is the start of the second period. It falls on the clock after enable goes low.
- R10: A period or duty write is buffered. It reaches the counter only at a wrap, or while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Runs the timebase; when low the counter holds at 0 |
| timing_wr_i | input | 1 | Strobe that captures period_i and duty_i into the buffers |
| period_i | input | CW | Period value (cycles minus one) |
| duty_i | input | CW | Duty value (high cycles) |
| steer_wr_i | input | 1 | Strobe that captures steer_i |
| steer_i | input | 4 | Steering bits, bit 0 = A … bit 3 = D |
| steer_sync_i | input | 1 | 0 = apply at once, 1 = apply at next wrap |
| pol_i | input | 2 | Pair polarity, bit 1 for A/C, bit 0 for B/D |
| port_data_i | input | 4 | Data shown on unsteered pins |
| oe_i | input | 4 | Per-pin drive enable |
| shutdown_i | input | 1 | Parks steered pins at their inactive level |
| pin_val_o | output | 4 | Pin values (0 when not driven) |
| pin_drv_o | output | 4 | Pin drive flags; 0 means high-impedance |
| cycle_done_o | output | 1 | First full period completed since enable |

## Verification
The hardest case to reach from the ports is a synchronized steering write that is still held when the counter wraps. The write must land strictly between two wraps, and the bench must see the old pattern survive right up to the wrap and then switch on exactly that edge. The stimulus uses a ten-cycle period and issues the held write a few cycles into a period. It then issues an immediate write mid-pulse so that a truncated high phase appears. A behavioural model counts the period itself and predicts every pin on every clock.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int NPIN = 4;
  typedef logic [NPIN-1:0] pin_vec_t;

  // Pins with even index (A, C) follow pol[1]; odd (B, D) follow pol[0].
  function automatic logic pair_invert(input logic [1:0] pol, input int idx);
    return (idx % 2 == 0) ? pol[1] : pol[0];
  endfunction
endpackage

// File: rtl/pst_timebase.sv
module pst_timebase #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          tm_wr_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] duty_i,
  output logic          pwm_o,
  output logic          start_o,
  output logic          done_o
);
  logic [CW-1:0] per_buf, duty_buf, per_q, duty_q, cnt_q;
  logic          done_q;

  assign start_o = en_i && (cnt_q == per_q);
  assign pwm_o   = en_i && (cnt_q < duty_q);
  assign done_o  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
      per_q    <= '0;
      duty_q   <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (tm_wr_i) begin
        per_buf  <= period_i;
        duty_buf <= duty_i;
      end
      if (!en_i) begin
        cnt_q  <= '0;
        per_q  <= per_buf;
        duty_q <= duty_buf;
        done_q <= 1'b0;
      end else if (start_o) begin
        cnt_q  <= '0;
        per_q  <= per_buf;
        duty_q <= duty_buf;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q <= per_q));
  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !done_o);
  // R10
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !start_o) |=> ($stable(per_q) && $stable(duty_q)));
endmodule

// File: rtl/pst_steer_reg.sv
module pst_steer_reg
  import pwm_steer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  logic     sync_i,
  input  pin_vec_t steer_i,
  input  logic     start_i,
  output pin_vec_t steer_o
);
  pin_vec_t steer_q, pend_q;
  logic     pend_v;

  assign steer_o = steer_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      steer_q <= '0;
      pend_q  <= '0;
      pend_v  <= 1'b0;
    end else if (wr_i) begin
      if (sync_i) begin
        pend_q <= steer_i;
        pend_v <= 1'b1;
      end else begin
        steer_q <= steer_i;
        pend_v  <= 1'b0;
      end
    end else if (start_i && pend_v) begin
      steer_q <= pend_q;
      pend_v  <= 1'b0;
    end
  end

  // R4
  steer_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !sync_i) |=> (steer_o == $past(steer_i)));
  // R5
  steer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(wr_i && !sync_i)) |=> $stable(steer_o));
endmodule

// File: rtl/pst_pin_drive.sv
module pst_pin_drive
  import pwm_steer_pkg::*;
(
  input  logic       pwm_i,
  input  pin_vec_t   steer_i,
  input  logic [1:0] pol_i,
  input  pin_vec_t   port_i,
  input  pin_vec_t   oe_i,
  input  logic       shut_i,
  output pin_vec_t   val_o,
  output pin_vec_t   drv_o
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic inv, steered_val, raw_val;
    assign inv         = pair_invert(pol_i, g);
    assign steered_val = shut_i ? inv : (pwm_i ^ inv);
    assign raw_val     = steer_i[g] ? steered_val : port_i[g];
    assign val_o[g]    = oe_i[g] & raw_val;
    assign drv_o[g]    = oe_i[g];
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic          timing_wr_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] duty_i,
  input  logic          steer_wr_i,
  input  logic [3:0]    steer_i,
  input  logic          steer_sync_i,
  input  logic [1:0]    pol_i,
  input  logic [3:0]    port_data_i,
  input  logic [3:0]    oe_i,
  input  logic          shutdown_i,
  output logic [3:0]    pin_val_o,
  output logic [3:0]    pin_drv_o,
  output logic          cycle_done_o
);
  logic     pwm_raw, period_start;
  pin_vec_t steer_act;

  pst_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .en_i(enable_i), .tm_wr_i(timing_wr_i),
    .period_i(period_i), .duty_i(duty_i),
    .pwm_o(pwm_raw), .start_o(period_start), .done_o(cycle_done_o)
  );

  pst_steer_reg u_steer (
    .clk(clk), .rst_n(rst_n), .wr_i(steer_wr_i), .sync_i(steer_sync_i),
    .steer_i(steer_i), .start_i(period_start), .steer_o(steer_act)
  );

  pst_pin_drive u_drv (
    .pwm_i(pwm_raw), .steer_i(steer_act), .pol_i(pol_i),
    .port_i(port_data_i), .oe_i(oe_i), .shut_i(shutdown_i),
    .val_o(pin_val_o), .drv_o(pin_drv_o)
  );

  // R7
  shut_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_i && steer_act[0] && oe_i[0]) |-> (pin_val_o[0] == pol_i[1]));
  // R8
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_val_o & ~pin_drv_o) == 4'b0000);
endmodule

// File: tb/test_pwm_steer.sv
module test_pwm_steer;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 0, timing_wr_i = 0, steer_wr_i = 0, steer_sync_i = 0, shutdown_i = 0;
  logic [CW-1:0] period_i = '0, duty_i = '0;
  logic [3:0] steer_i = '0, port_data_i = '0, oe_i = '0;
  logic [1:0] pol_i = '0;
  logic [3:0] pin_val_o, pin_drv_o;
  logic cycle_done_o;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit checking = 0;

  always #10 clk = ~clk;

  pwm_steer #(.CW(CW)) i_pwm_steer (.*);

  // behavioural reference model
  int m_cnt, m_per, m_duty, m_pbuf, m_dbuf;
  logic [3:0] m_steer, m_pend;
  bit m_pv, m_done;

  always @(posedge clk) begin
    bit st;
    if (!rst_n) begin
      m_cnt = 0; m_per = 0; m_duty = 0; m_pbuf = 0; m_dbuf = 0;
      m_steer = 0; m_pend = 0; m_pv = 0; m_done = 0;
    end else begin
      st = enable_i && (m_cnt == m_per);
      if (steer_wr_i) begin
        if (steer_sync_i) begin m_pend = steer_i; m_pv = 1; end
        else begin m_steer = steer_i; m_pv = 0; end
      end else if (st && m_pv) begin
        m_steer = m_pend; m_pv = 0;
      end
      if (!enable_i) begin
        m_cnt = 0; m_per = m_pbuf; m_duty = m_dbuf; m_done = 0;
      end else if (st) begin
        m_cnt = 0; m_per = m_pbuf; m_duty = m_dbuf; m_done = 1;
      end else m_cnt++;
      if (timing_wr_i) begin m_pbuf = period_i; m_dbuf = duty_i; end
    end
  end

  function automatic logic [3:0] exp_val();
    logic [3:0] r;
    bit raw;
    raw = enable_i && (m_cnt < m_duty);
    for (int i = 0; i < 4; i++) begin
      bit inv, v;
      inv = (i % 2 == 0) ? pol_i[1] : pol_i[0];
      if (m_steer[i]) v = shutdown_i ? inv : (raw ^ inv);
      else v = port_data_i[i];
      r[i] = oe_i[i] & v;
    end
    return r;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && checking) begin
      check(cur_req, "pin values", pin_val_o, exp_val());
      check(cur_req, "pin drive", pin_drv_o, oe_i);
      check(cur_req, "done flag", cycle_done_o, m_done);
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic set_timing(int p, int d);
    period_i = p[CW-1:0]; duty_i = d[CW-1:0]; timing_wr_i = 1; step(); timing_wr_i = 0;
  endtask

  task automatic set_steer(logic [3:0] s, bit sync);
    steer_i = s; steer_sync_i = sync; steer_wr_i = 1; step(); steer_wr_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1; oe_i = 4'hF; port_data_i = 4'b1010;
    @(negedge clk);
    // R1: reset state, steering cleared so pins show port data
    check("R1", "done after reset", cycle_done_o, 0);
    check("R1", "pins after reset", pin_val_o, 4'b1010);
    checking = 1;
    step();
    // R10: timing buffered, loaded while disabled
    cur_req = "R10"; set_timing(9, 4);
    cur_req = "R2"; enable_i = 1; set_steer(4'hF, 0); step(30);
    // R9: flag high after first wrap
    @(negedge clk); check("R9", "done after full cycle", cycle_done_o, 1);
    step();
    cur_req = "R3"; port_data_i = 4'b1010; set_steer(4'b0101, 0); step(12);
    // R4: immediate write mid-pulse
    cur_req = "R4"; set_steer(4'hF, 0);
    while (m_cnt != 2) step();
    set_steer(4'h0, 0);
    @(negedge clk); check("R4", "truncated to port data", pin_val_o, port_data_i);
    step(5);
    // R5: held write, then replaced before wrap
    cur_req = "R5"; while (m_cnt != 3) step();
    set_steer(4'b0011, 1); step(2); set_steer(4'b1100, 1); step(25);
    cur_req = "R6";
    for (int p = 0; p < 4; p++) begin pol_i = p[1:0]; step(12); end
    cur_req = "R7"; pol_i = 2'b10; set_steer(4'b0011, 0); port_data_i = 4'b1100;
    shutdown_i = 1; step(12);
    @(negedge clk); check("R7", "shutdown park", pin_val_o, 4'b1101);
    step(); shutdown_i = 0; step(4);
    cur_req = "R8"; oe_i = 4'b0110; step(12); oe_i = 4'hF;
    cur_req = "R10"; set_steer(4'hF, 0); while (m_cnt != 3) step();
    set_timing(5, 2); step(20); set_timing(5, 0); step(15); set_timing(5, 7); step(15);
    cur_req = "R9"; enable_i = 0; step(3);
    @(negedge clk); check("R9", "done after disable", cycle_done_o, 0);
    step(); set_timing(9, 4); step(); enable_i = 1; step(25);
    checking = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule